// File: doc/BRIEF.md
# E1 Spare-Bit Data-Link Strobe Generator

This block produces a receive-side qualifying strobe for the national spare bits of an E1 stream. A framer supplies its timing: a per-bit clock enable, a frame-aligned bit counter running 0 to 255, a flag that marks frames without the frame alignment signal, and an in-sync flag. From these the block finds the five spare-bit positions of timeslot 0. For each position whose select bit is set, it raises a registered strobe for that one bit period.

The strobe runs beside the framer's registered receive data. A downstream device can then use it as a capture enable and pick up only the chosen spare bits. An 8-bit control input carries one select per spare bit. Any mix of the five may be active in the same frame. In frames that carry the alignment word, and whenever the framer is out of sync, the strobe stays low.

Top module: `e1_spare_strobe`

## Requirements
- R1: While reset is applied and after it is released, `strobe` is 0 until a qualifying bit is seen.
- R2: When `bit_en` is 1 in a cycle where `bit_pos` is 3 to 7, `nfas_frame` is 1 and `in_sync` is 1, and the select for that bit is 1, `strobe` is 1 in the following cycle. The select for count p is `sa_sel[p]`, so counts 3 to 7 (spare bits 4 to 8) use `sa_sel` bits 3 to 7.
- R3: Under the same conditions, but with that position's select at 0, `strobe` is 0 in the following cycle.
- R4: A bit whose `nfas_frame` is 0 (a frame that carries the alignment word) gives `strobe` 0, whatever the selects are.
- R5: A bit whose `in_sync` is 0 gives `strobe` 0, whatever the selects are.
- R6: A bit whose `bit_pos` is 0 to 2 or 8 to 255 gives `strobe` 0, even with all selects set.
- R7: `strobe` changes only on a clock edge where `bit_en` was 1. In cycles with `bit_en` at 0 it holds its value, whatever the other inputs do.
- R8: `sa_sel` bits 0 to 2 have no effect on `strobe`.
- R9: Each select acts on its own, so any of the 32 subsets of the five positions gives strobes at exactly the selected positions within one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One-cycle enable marking each received bit |
| bit_pos | input | 8 | Frame-aligned bit counter, 0 to 255 |
| nfas_frame | input | 1 | 1 when the current frame does not carry the alignment word |
| in_sync | input | 1 | 1 when the framer holds frame alignment |
| sa_sel | input | 8 | Control: bits 3 to 7 select spare bits 4 to 8; bits 0 to 2 unused |
| strobe | output | 1 | Registered spare-bit strobe, valid for one bit period |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a spare window that starts at count 3 and spans five positions, and selects that start at control bit 3. With these values it can sweep every one of the 32 select masks over a complete 256-bit frame. This covers both window edges and all counts outside the window. The bench repeats the sweep with the alignment flag and the sync flag cleared, toggles the unused control bits, and inserts idle cycles after a high strobe to show that the value holds.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int unsigned POS_W_DEF    = 8;
  localparam int unsigned SA_FIRST_DEF = 3;
  localparam int unsigned SA_COUNT_DEF = 5;
  localparam int unsigned CTRL_W_DEF   = 8;
  localparam int unsigned SEL_LSB_DEF  = 3;
endpackage

// File: rtl/e1_sa_pos_decode.sv
module e1_sa_pos_decode #(
  parameter int unsigned POS_W    = 8,
  parameter int unsigned SA_FIRST = 3,
  parameter int unsigned SA_COUNT = 5
) (
  input  logic [POS_W-1:0]    bit_pos,
  output logic [SA_COUNT-1:0] hit
);
  // one comparator per spare position
  for (genvar k = 0; k < SA_COUNT; k++) begin : g_pos
    localparam logic [POS_W-1:0] POS_K = POS_W'(SA_FIRST + k);
    assign hit[k] = (bit_pos == POS_K);
  end
endmodule

// File: rtl/e1_sa_gate.sv
module e1_sa_gate #(
  parameter int unsigned SA_COUNT = 5
) (
  input  logic [SA_COUNT-1:0] hit,
  input  logic [SA_COUNT-1:0] sel,
  input  logic                nfas_frame,
  input  logic                in_sync,
  output logic                pulse
);
  logic frame_ok;

  always_comb begin
    frame_ok = nfas_frame & in_sync;
    pulse    = frame_ok & (|(hit & sel));
  end
endmodule

// File: rtl/e1_spare_strobe.sv
module e1_spare_strobe
  import e1_sa_pkg::*;
#(
  parameter int unsigned POS_W    = POS_W_DEF,
  parameter int unsigned SA_FIRST = SA_FIRST_DEF,
  parameter int unsigned SA_COUNT = SA_COUNT_DEF,
  parameter int unsigned CTRL_W   = CTRL_W_DEF,
  parameter int unsigned SEL_LSB  = SEL_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              nfas_frame,
  input  logic              in_sync,
  input  logic [CTRL_W-1:0] sa_sel,
  output logic              strobe
);
  localparam int unsigned SA_LAST = SA_FIRST + SA_COUNT - 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [SA_COUNT-1:0] sel;
  logic [SA_COUNT-1:0] hit;
  logic                pulse;
  logic                unused_ctrl;

  assign sel         = sa_sel[SEL_LSB +: SA_COUNT];
  assign unused_ctrl = ^sa_sel[SEL_LSB-1:0];

  e1_sa_pos_decode #(
    .POS_W   (POS_W),
    .SA_FIRST(SA_FIRST),
    .SA_COUNT(SA_COUNT)
  ) u_decode (
    .bit_pos(bit_pos),
    .hit    (hit)
  );

  e1_sa_gate #(
    .SA_COUNT(SA_COUNT)
  ) u_gate (
    .hit       (hit),
    .sel       (sel),
    .nfas_frame(nfas_frame),
    .in_sync   (in_sync),
    .pulse     (pulse)
  );

  // next state: update only on bit enable
  logic strobe_d, strobe_q;
  always_comb begin
    strobe_d = strobe_q;
    if (bit_en) strobe_d = pulse;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) strobe_q <= 1'b0;
    else             strobe_q <= strobe_d;
  end

  assign strobe = strobe_q;

  // checks on the output register
  assert_fas_blank_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_en && !nfas_frame) |=> !strobe);

  assert_sync_blank_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_en && !in_sync) |=> !strobe);

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_en && ((bit_pos < POS_W'(SA_FIRST)) || (bit_pos > POS_W'(SA_LAST)))) |=> !strobe);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bit_en |=> $stable(strobe));

  assert_rise_src_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(strobe) |-> $past(bit_en && nfas_frame && in_sync));
endmodule

// File: tb/tb_e1_spare_strobe.sv
module tb_e1_spare_strobe;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic [7:0] bit_pos;
  logic       nfas_frame;
  logic       in_sync;
  logic [7:0] sa_sel;
  logic       strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  e1_spare_strobe dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_pos   (bit_pos),
    .nfas_frame(nfas_frame),
    .in_sync   (in_sync),
    .sa_sel    (sa_sel),
    .strobe    (strobe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: strobe=%b expected=%b (pos=%0d sel=%h)", req, act, exp, bit_pos, sa_sel);
    end
  endtask

  // model: count p in 3..7 uses select bit p
  function automatic logic model(input int p, input logic nf, input logic sy, input logic [7:0] s);
    return nf && sy && (p >= 3) && (p <= 7) && s[p];
  endfunction

  // present one bit, sample after the capturing edge
  task automatic step(input int p, input logic nf, input logic sy, input string req);
    bit_en = 1'b1; bit_pos = 8'(p); nfas_frame = nf; in_sync = sy;
    @(negedge clk);
    chk(req, strobe, model(p, nf, sy, sa_sel));
  endtask

  task automatic frame(input logic nf, input logic sy, input string req);
    for (int p = 0; p < 256; p++) step(p, nf, sy, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_en = 1'b0; bit_pos = '0; nfas_frame = 1'b1; in_sync = 1'b1; sa_sel = 8'hF8;
    repeat (3) @(negedge clk);
    chk("R1 in reset", strobe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", strobe, 1'b0);
  endtask

  task automatic t_single;
    for (int k = 3; k <= 7; k++) begin
      sa_sel = 8'(1 << k);
      step(k, 1'b1, 1'b1, "R2 single select");
      step(k + 1, 1'b1, 1'b1, "R3 neighbour unselected");
    end
    sa_sel = 8'h00;
    for (int k = 3; k <= 7; k++) step(k, 1'b1, 1'b1, "R3 all deselected");
  endtask

  task automatic t_subsets;
    for (int m = 0; m < 32; m++) begin
      sa_sel = 8'(m << 3);
      frame(1'b1, 1'b1, "R9 subset sweep R6");
    end
  endtask

  task automatic t_blank;
    sa_sel = 8'hF8;
    frame(1'b0, 1'b1, "R4 alignment frame");
    frame(1'b1, 1'b0, "R5 out of sync");
  endtask

  task automatic t_unused;
    for (int u = 0; u < 8; u++) begin
      sa_sel = {5'b10101, 3'(u)};
      for (int p = 0; p < 10; p++) step(p, 1'b1, 1'b1, "R8 unused bits");
    end
  endtask

  task automatic t_hold;
    sa_sel = 8'h20;
    step(5, 1'b1, 1'b1, "R7 setup high");
    bit_en = 1'b0; bit_pos = 8'd0; nfas_frame = 1'b0; in_sync = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R7 hold high", strobe, 1'b1);
    end
    step(6, 1'b1, 1'b1, "R7 setup low");
    bit_en = 1'b0; bit_pos = 8'd5; nfas_frame = 1'b1; in_sync = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R7 hold low", strobe, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_subsets();
    t_blank();
    t_unused();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule